// File: doc/BRIEF.md
# Split Load Tracker

The tracker accepts one load at a time and issues it to the data cache as one request or two. If the load crosses an alignment boundary, the caller marks it as split and supplies the address and byte count of each half. The tracker then offers the low half on one request channel and the high half on a second channel the next cycle. A request is offered for exactly one cycle. If the cache does not take it in that cycle, it counts as rejected.

Each accepted load carries a count of outstanding halves: one for a plain load and two for a split load. Every response lowers the count. Responses for the two halves may return in either order. The low half's bytes land at the bottom of a byte buffer, and the high half's bytes land directly above them, starting at the low half's byte count. When the count reaches zero the tracker reports one outcome for the whole load:
- a completion with the merged data, or
- a replay if the high half had been rejected.

A rejected low half abandons the load at once and reports a retry.

Top module: `split_load_tracker`

## Requirements
- R1: While reset is high and in the first cycle after it, `ld_ready` is 1. `lo_req_valid`, `hi_req_valid`, `done_valid`, `retry_valid` and `replay_valid` are all 0.
- R2: A load is accepted in a cycle where `ld_valid` and `ld_ready` are both 1. In the next cycle `lo_req_valid` is 1, with the accepted low address and low byte count.
- R3: If `lo_req_ready` is 0 in the cycle `lo_req_valid` is 1, the load is dropped. The next cycle shows `retry_valid` 1, `ld_ready` 1, no high request and no completion.
- R4: A plain load (`ld_split` 0) whose low request is accepted completes on its single response. `done_valid` is 1 in the cycle after that response. `done_data` byte b equals response byte b for b below the low byte count, and is 0 above it.
- R5: For a split load whose low request is accepted, `hi_req_valid` is 1 in the next cycle, with the high address and high byte count. Completion waits for both responses. `rsp_hi` = 0 marks a low-half response and 1 a high-half response, in either order.
- R6: In a completed split load, `done_data` byte (low count + i) equals byte i of the high-half response. Bytes below the low count come from the low-half response. Bytes beyond both halves are 0.
- R7: A split load yields exactly one `done_valid` pulse, one cycle wide, in the cycle after its last response. No pulse follows its first response.
- R8: If `hi_req_ready` is 0 in the cycle `hi_req_valid` is 1, the low response is discarded and no completion is reported. `replay_valid` pulses in the cycle after the low response has returned. If the low response returned during the rejected cycle, the pulse comes in the cycle right after that cycle.
- R9: From acceptance until the cycle in which its outcome pulse appears, `ld_ready` is 0. Any `ld_valid` in that window starts no request.
- R10: At most one of `done_valid`, `retry_valid` and `replay_valid` is 1 in any cycle, and each is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load request present |
| ld_ready | output | 1 | Tracker idle, load can be taken |
| ld_split | input | 1 | Load is issued as two halves |
| ld_lo_addr | input | ADDR_W | Low-half address |
| ld_hi_addr | input | ADDR_W | High-half address |
| ld_lo_size | input | SIZE_W | Low-half byte count (whole size if not split) |
| ld_hi_size | input | SIZE_W | High-half byte count |
| lo_req_valid | output | 1 | Low-half cache request offered this cycle |
| lo_req_ready | input | 1 | Cache takes the low-half request |
| lo_req_addr | output | ADDR_W | Low-half request address |
| lo_req_size | output | SIZE_W | Low-half request byte count |
| hi_req_valid | output | 1 | High-half cache request offered this cycle |
| hi_req_ready | input | 1 | Cache takes the high-half request |
| hi_req_addr | output | ADDR_W | High-half request address |
| hi_req_size | output | SIZE_W | High-half request byte count |
| rsp_valid | input | 1 | Cache response present |
| rsp_hi | input | 1 | Response belongs to the high half |
| rsp_data | input | 8*BUF_BYTES | Response bytes, first byte in bits 7:0 |
| done_valid | output | 1 | Load completed |
| done_data | output | 8*BUF_BYTES | Merged load bytes |
| retry_valid | output | 1 | Low half rejected, load dropped |
| replay_valid | output | 1 | High half rejected, load must replay |

## Verification
A wrong outstanding count shows up at the ports within one cycle of the last response. A count that is too low gives `done_valid` after the first half of a split load. A count that is too high leaves `ld_ready` low with no outcome pulse, which the next load's readiness check catches. A lost or wrong blocked flag turns an expected replay into a completion in the cycle after the low response. A wrong merge offset corrupts `done_data` bytes at or above the low byte count, and these are compared against a model of the byte placement. A high request issued when the low half was rejected shows as `hi_req_valid` in the retry cycle.

// File: rtl/slt_pkg.sv
package slt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SEND_LO = 2'd1,
    ST_SEND_HI = 2'd2,
    ST_WAIT    = 2'd3
  } slt_state_e;

  typedef enum logic [1:0] {
    OUT_NONE   = 2'd0,
    OUT_DONE   = 2'd1,
    OUT_RETRY  = 2'd2,
    OUT_REPLAY = 2'd3
  } slt_outcome_e;

endpackage

// File: rtl/slt_ctrl.sv
module slt_ctrl
  import slt_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         ld_fire,
  input  logic         ld_split,
  input  logic         lo_ready,
  input  logic         hi_ready,
  input  logic         rsp_valid,
  output slt_state_e   state_o,
  output logic         buf_we,
  output logic         fin_ok,
  output slt_outcome_e outcome_o
);

  slt_state_e   state_q, state_d;
  slt_outcome_e outcome_q, outcome_d;
  logic [1:0]   cnt_q, cnt_d;
  logic         blk_q, blk_d;
  logic         split_q, split_d;

  logic         rsp_take;
  logic         hi_rej;
  logic [1:0]   cnt_dec;
  logic [1:0]   cnt_after;
  logic         blk_after;

  // a response only counts once the low half has been taken by the cache
  assign rsp_take  = rsp_valid && ((state_q == ST_SEND_HI) || (state_q == ST_WAIT));
  assign hi_rej    = (state_q == ST_SEND_HI) && !hi_ready;
  assign cnt_dec   = {1'b0, rsp_take} + {1'b0, hi_rej};
  assign cnt_after = (cnt_q > cnt_dec) ? (cnt_q - cnt_dec) : 2'd0;
  assign blk_after = blk_q || hi_rej;

  assign buf_we = rsp_take && !blk_after;
  assign fin_ok = rsp_take && (cnt_after == 2'd0) && !blk_after;

  always_comb begin
    state_d   = state_q;
    outcome_d = OUT_NONE;
    cnt_d     = cnt_q;
    blk_d     = blk_q;
    split_d   = split_q;
    unique case (state_q)
      ST_IDLE: begin
        if (ld_fire) begin
          state_d = ST_SEND_LO;
          split_d = ld_split;
          cnt_d   = ld_split ? 2'd2 : 2'd1;
          blk_d   = 1'b0;
        end
      end
      ST_SEND_LO: begin
        if (lo_ready) begin
          state_d = split_q ? ST_SEND_HI : ST_WAIT;
        end else begin
          state_d   = ST_IDLE;
          outcome_d = OUT_RETRY;
          cnt_d     = 2'd0;
          blk_d     = 1'b0;
        end
      end
      ST_SEND_HI, ST_WAIT: begin
        cnt_d = cnt_after;
        blk_d = blk_after;
        if (cnt_after == 2'd0) begin
          state_d   = ST_IDLE;
          outcome_d = blk_after ? OUT_REPLAY : OUT_DONE;
        end else begin
          state_d = ST_WAIT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      outcome_q <= OUT_NONE;
      cnt_q     <= 2'd0;
      blk_q     <= 1'b0;
      split_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      outcome_q <= outcome_d;
      cnt_q     <= cnt_d;
      blk_q     <= blk_d;
      split_q   <= split_d;
    end
  end

  assign state_o   = state_q;
  assign outcome_o = outcome_q;

endmodule

// File: rtl/slt_byte_merge.sv
module slt_byte_merge #(
  parameter int BUF_BYTES = 8,
  parameter int SIZE_W    = 4,
  localparam int DW       = 8 * BUF_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              we,
  input  logic              we_hi,
  input  logic [SIZE_W-1:0] lo_size,
  input  logic [SIZE_W-1:0] hi_size,
  input  logic [DW-1:0]     rsp_data,
  input  logic              capture,
  output logic [DW-1:0]     merged
);

  logic [DW-1:0] buf_q;
  logic [DW-1:0] buf_d;
  logic [DW-1:0] hi_placed;
  logic [SIZE_W:0] hi_end;
  logic [DW-1:0] merged_q;

  // high-half bytes shifted up so that byte i sits at lo_size + i
  assign hi_placed = rsp_data << (8 * lo_size);
  assign hi_end    = {1'b0, lo_size} + {1'b0, hi_size};

  for (genvar g = 0; g < BUF_BYTES; g++) begin : g_lane
    localparam logic [SIZE_W:0] LANE = (SIZE_W+1)'(g);
    logic lo_hit;
    logic hi_hit;
    assign lo_hit = !we_hi && (LANE < {1'b0, lo_size});
    assign hi_hit = we_hi && (LANE >= {1'b0, lo_size}) && (LANE < hi_end);
    always_comb begin
      buf_d[8*g +: 8] = buf_q[8*g +: 8];
      if (clear) begin
        buf_d[8*g +: 8] = 8'h00;
      end else if (we && lo_hit) begin
        buf_d[8*g +: 8] = rsp_data[8*g +: 8];
      end else if (we && hi_hit) begin
        buf_d[8*g +: 8] = hi_placed[8*g +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q    <= '0;
      merged_q <= '0;
    end else begin
      buf_q <= buf_d;
      if (capture) begin
        merged_q <= buf_d;
      end
    end
  end

  assign merged = merged_q;

endmodule

// File: rtl/split_load_tracker.sv
module split_load_tracker
  import slt_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BUF_BYTES = 8,
  localparam int SIZE_W   = $clog2(BUF_BYTES + 1),
  localparam int DW       = 8 * BUF_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic              ld_split,
  input  logic [ADDR_W-1:0] ld_lo_addr,
  input  logic [ADDR_W-1:0] ld_hi_addr,
  input  logic [SIZE_W-1:0] ld_lo_size,
  input  logic [SIZE_W-1:0] ld_hi_size,
  output logic              lo_req_valid,
  input  logic              lo_req_ready,
  output logic [ADDR_W-1:0] lo_req_addr,
  output logic [SIZE_W-1:0] lo_req_size,
  output logic              hi_req_valid,
  input  logic              hi_req_ready,
  output logic [ADDR_W-1:0] hi_req_addr,
  output logic [SIZE_W-1:0] hi_req_size,
  input  logic              rsp_valid,
  input  logic              rsp_hi,
  input  logic [DW-1:0]     rsp_data,
  output logic              done_valid,
  output logic [DW-1:0]     done_data,
  output logic              retry_valid,
  output logic              replay_valid
);

  slt_state_e   state;
  slt_outcome_e outcome;
  logic         ld_fire;
  logic         buf_we;
  logic         fin_ok;

  logic [ADDR_W-1:0] lo_addr_q, hi_addr_q;
  logic [SIZE_W-1:0] lo_size_q, hi_size_q;

  assign ld_ready = (state == ST_IDLE);
  assign ld_fire  = ld_valid && ld_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_addr_q <= '0;
      hi_addr_q <= '0;
      lo_size_q <= '0;
      hi_size_q <= '0;
    end else if (ld_fire) begin
      lo_addr_q <= ld_lo_addr;
      hi_addr_q <= ld_hi_addr;
      lo_size_q <= ld_lo_size;
      hi_size_q <= ld_split ? ld_hi_size : '0;
    end
  end

  slt_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .ld_fire   (ld_fire),
    .ld_split  (ld_split),
    .lo_ready  (lo_req_ready),
    .hi_ready  (hi_req_ready),
    .rsp_valid (rsp_valid),
    .state_o   (state),
    .buf_we    (buf_we),
    .fin_ok    (fin_ok),
    .outcome_o (outcome)
  );

  slt_byte_merge #(
    .BUF_BYTES (BUF_BYTES),
    .SIZE_W    (SIZE_W)
  ) u_merge (
    .clk      (clk),
    .rst      (rst),
    .clear    (ld_fire),
    .we       (buf_we),
    .we_hi    (rsp_hi),
    .lo_size  (lo_size_q),
    .hi_size  (hi_size_q),
    .rsp_data (rsp_data),
    .capture  (fin_ok),
    .merged   (done_data)
  );

  assign lo_req_valid = (state == ST_SEND_LO);
  assign hi_req_valid = (state == ST_SEND_HI);
  assign lo_req_addr  = lo_addr_q;
  assign lo_req_size  = lo_size_q;
  assign hi_req_addr  = hi_addr_q;
  assign hi_req_size  = hi_size_q;

  assign done_valid   = (outcome == OUT_DONE);
  assign retry_valid  = (outcome == OUT_RETRY);
  assign replay_valid = (outcome == OUT_REPLAY);

endmodule

// File: rtl/slt_checks.sv
module slt_checks (
  input logic clk,
  input logic rst,
  input logic ld_valid,
  input logic ld_ready,
  input logic lo_req_valid,
  input logic lo_req_ready,
  input logic hi_req_valid,
  input logic rsp_valid,
  input logic done_valid,
  input logic retry_valid,
  input logic replay_valid
);

  // R2
  a_r2_accept_issues_low: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_ready) |=> (lo_req_valid && !ld_ready));

  // R3
  a_r3_low_reject_retries: assert property (@(posedge clk) disable iff (rst)
    (lo_req_valid && !lo_req_ready) |=> (retry_valid && ld_ready && !hi_req_valid));

  // R5
  a_r5_high_follows_low: assert property (@(posedge clk) disable iff (rst)
    hi_req_valid |-> $past(lo_req_valid && lo_req_ready));

  // R4
  a_r4_done_after_response: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> $past(rsp_valid));

  // R9
  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    (lo_req_valid || hi_req_valid) |-> !ld_ready);

  // R10
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done_valid, retry_valid, replay_valid}));

  // R10
  a_r10_done_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);

  // R10
  a_r10_replay_single_pulse: assert property (@(posedge clk) disable iff (rst)
    replay_valid |=> !replay_valid);

endmodule

bind split_load_tracker slt_checks u_slt_checks (
  .clk          (clk),
  .rst          (rst),
  .ld_valid     (ld_valid),
  .ld_ready     (ld_ready),
  .lo_req_valid (lo_req_valid),
  .lo_req_ready (lo_req_ready),
  .hi_req_valid (hi_req_valid),
  .rsp_valid    (rsp_valid),
  .done_valid   (done_valid),
  .retry_valid  (retry_valid),
  .replay_valid (replay_valid)
);

// File: tb/split_load_tracker_test.sv
module split_load_tracker_test;

  localparam int AW     = 32;
  localparam int NB     = 8;
  localparam int SW     = $clog2(NB + 1);
  localparam int DW     = 8 * NB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_valid = 1'b0;
  logic          ld_ready;
  logic          ld_split = 1'b0;
  logic [AW-1:0] ld_lo_addr = '0;
  logic [AW-1:0] ld_hi_addr = '0;
  logic [SW-1:0] ld_lo_size = '0;
  logic [SW-1:0] ld_hi_size = '0;
  logic          lo_req_valid;
  logic          lo_req_ready = 1'b0;
  logic [AW-1:0] lo_req_addr;
  logic [SW-1:0] lo_req_size;
  logic          hi_req_valid;
  logic          hi_req_ready = 1'b0;
  logic [AW-1:0] hi_req_addr;
  logic [SW-1:0] hi_req_size;
  logic          rsp_valid = 1'b0;
  logic          rsp_hi = 1'b0;
  logic [DW-1:0] rsp_data = '0;
  logic          done_valid;
  logic [DW-1:0] done_data;
  logic          retry_valid;
  logic          replay_valid;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  split_load_tracker #(.ADDR_W(AW), .BUF_BYTES(NB)) uut (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_split(ld_split),
    .ld_lo_addr(ld_lo_addr), .ld_hi_addr(ld_hi_addr),
    .ld_lo_size(ld_lo_size), .ld_hi_size(ld_hi_size),
    .lo_req_valid(lo_req_valid), .lo_req_ready(lo_req_ready),
    .lo_req_addr(lo_req_addr), .lo_req_size(lo_req_size),
    .hi_req_valid(hi_req_valid), .hi_req_ready(hi_req_ready),
    .hi_req_addr(hi_req_addr), .hi_req_size(hi_req_size),
    .rsp_valid(rsp_valid), .rsp_hi(rsp_hi), .rsp_data(rsp_data),
    .done_valid(done_valid), .done_data(done_data),
    .retry_valid(retry_valid), .replay_valid(replay_valid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd_data();
    return {$urandom, $urandom};
  endfunction

  function automatic logic [DW-1:0] exp_merge(input bit sp, input int ls, input int hs,
                                              input logic [DW-1:0] lo,
                                              input logic [DW-1:0] hi);
    logic [DW-1:0] r;
    for (int b = 0; b < NB; b++) begin
      if (b < ls)                 r[8*b +: 8] = lo[8*b +: 8];
      else if (sp && b < ls + hs) r[8*b +: 8] = hi[8*(b-ls) +: 8];
      else                        r[8*b +: 8] = 8'h00;
    end
    return r;
  endfunction

  function automatic logic [2:0] pulses();
    return {done_valid, retry_valid, replay_valid};
  endfunction

  task automatic run_load(input bit sp, input logic [AW-1:0] la, input logic [AW-1:0] ha,
                          input int ls, input int hs, input bit lo_ok, input bit hi_ok,
                          input bit lo_early, input bit hi_first, input int gap);
    logic [DW-1:0] dl;
    logic [DW-1:0] dh;
    logic [DW-1:0] ex;
    dl = rnd_data();
    dh = rnd_data();
    ex = exp_merge(sp, ls, hs, dl, dh);
    @(negedge clk);
    chk(ld_ready == 1'b1, "R9", "ready before load", DW'(ld_ready), DW'(1));
    ld_valid   = 1'b1;
    ld_split   = sp;
    ld_lo_addr = la;
    ld_hi_addr = ha;
    ld_lo_size = SW'(ls);
    ld_hi_size = SW'(hs);
    @(negedge clk);
    ld_valid = 1'b0;
    chk(lo_req_valid && lo_req_addr == la && lo_req_size == SW'(ls), "R2", "low request",
        DW'({lo_req_valid, lo_req_size, lo_req_addr}), DW'({1'b1, SW'(ls), la}));
    chk(!ld_ready, "R9", "busy after accept", DW'(ld_ready), DW'(0));
    lo_req_ready = lo_ok;
    @(negedge clk);
    lo_req_ready = 1'b0;
    if (!lo_ok) begin
      chk(pulses() == 3'b010 && ld_ready && !hi_req_valid, "R3", "retry after low reject",
          DW'({pulses(), ld_ready, hi_req_valid}), DW'({3'b010, 1'b1, 1'b0}));
      return;
    end
    if (sp) begin
      chk(hi_req_valid && hi_req_addr == ha && hi_req_size == SW'(hs), "R5", "high request",
          DW'({hi_req_valid, hi_req_size, hi_req_addr}), DW'({1'b1, SW'(hs), ha}));
      hi_req_ready = hi_ok;
      if (lo_early) begin
        rsp_valid = 1'b1; rsp_hi = 1'b0; rsp_data = dl;
      end
      @(negedge clk);
      hi_req_ready = 1'b0;
      rsp_valid    = 1'b0;
      if (!hi_ok) begin
        if (!lo_early) begin
          chk(pulses() == 3'b000, "R8", "no outcome before low returns",
              DW'(pulses()), DW'(0));
          rsp_valid = 1'b1; rsp_hi = 1'b0; rsp_data = dl;
          @(negedge clk);
          rsp_valid = 1'b0;
        end
        chk(pulses() == 3'b001, "R8", "replay after high reject", DW'(pulses()), DW'(3'b001));
        return;
      end
      if (!lo_early) begin
        rsp_valid = 1'b1; rsp_hi = hi_first; rsp_data = hi_first ? dh : dl;
        @(negedge clk);
        rsp_valid = 1'b0;
        chk(pulses() == 3'b000, "R7", "no outcome after first half", DW'(pulses()), DW'(0));
      end
      for (int i = 0; i < gap; i++) begin
        ld_valid = 1'b1; ld_lo_addr = $urandom;
        @(negedge clk);
        chk(!ld_ready && !lo_req_valid && !hi_req_valid && pulses() == 3'b000, "R9",
            "load ignored while busy", DW'({ld_ready, lo_req_valid, hi_req_valid, pulses()}), DW'(0));
      end
      ld_valid  = 1'b0;
      rsp_valid = 1'b1;
      rsp_hi    = lo_early ? 1'b1 : !hi_first;
      rsp_data  = rsp_hi ? dh : dl;
      @(negedge clk);
      rsp_valid = 1'b0;
      chk(pulses() == 3'b100, "R7", "single completion", DW'(pulses()), DW'(3'b100));
      chk(done_data == ex, "R6", "merged split data", done_data, ex);
      @(negedge clk);
      chk(pulses() == 3'b000, "R7", "no second completion", DW'(pulses()), DW'(0));
    end else begin
      for (int i = 0; i < gap; i++) begin
        ld_valid = 1'b1; ld_lo_addr = $urandom;
        @(negedge clk);
        chk(!ld_ready && !lo_req_valid && pulses() == 3'b000, "R9", "load ignored while busy",
            DW'({ld_ready, lo_req_valid, pulses()}), DW'(0));
      end
      ld_valid  = 1'b0;
      rsp_valid = 1'b1; rsp_hi = 1'b0; rsp_data = dl;
      @(negedge clk);
      rsp_valid = 1'b0;
      chk(pulses() == 3'b100, "R4", "plain completion", DW'(pulses()), DW'(3'b100));
      chk(done_data == ex, "R4", "plain data", done_data, ex);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(ld_ready && !lo_req_valid && !hi_req_valid && pulses() == 3'b000, "R1", "reset state",
        DW'({ld_ready, lo_req_valid, hi_req_valid, pulses()}), DW'({1'b1, 5'b0}));
    rst = 1'b0;
    @(negedge clk);
    chk(ld_ready && !lo_req_valid && !hi_req_valid && pulses() == 3'b000, "R1", "after reset",
        DW'({ld_ready, lo_req_valid, hi_req_valid, pulses()}), DW'({1'b1, 5'b0}));

    // directed corners
    run_load(1'b0, 32'h100, 32'h0, 8, 0, 1'b1, 1'b1, 1'b0, 1'b0, 0);
    run_load(1'b0, 32'h104, 32'h0, 3, 0, 1'b1, 1'b1, 1'b0, 1'b0, 2);
    run_load(1'b0, 32'h108, 32'h0, 4, 0, 1'b0, 1'b1, 1'b0, 1'b0, 0);
    run_load(1'b1, 32'h1FD, 32'h200, 3, 5, 1'b0, 1'b1, 1'b0, 1'b0, 0);
    run_load(1'b1, 32'h1FD, 32'h200, 3, 5, 1'b1, 1'b1, 1'b0, 1'b0, 1);
    run_load(1'b1, 32'h2FF, 32'h300, 1, 7, 1'b1, 1'b1, 1'b0, 1'b1, 0);
    run_load(1'b1, 32'h3F9, 32'h400, 7, 1, 1'b1, 1'b1, 1'b1, 1'b0, 0);
    run_load(1'b1, 32'h4FE, 32'h500, 2, 2, 1'b1, 1'b0, 1'b0, 1'b0, 0);
    run_load(1'b1, 32'h5FC, 32'h600, 4, 2, 1'b1, 1'b0, 1'b1, 1'b0, 0);
    run_load(1'b1, 32'h6FE, 32'h700, 2, 3, 1'b1, 1'b1, 1'b0, 1'b1, 3);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      bit sp;
      int ls;
      int hs;
      sp = $urandom_range(0, 1) == 1;
      if (sp) begin
        ls = $urandom_range(1, NB - 1);
        hs = $urandom_range(1, NB - ls);
      end else begin
        ls = $urandom_range(1, NB);
        hs = 0;
      end
      run_load(sp, $urandom, $urandom, ls, hs,
               $urandom_range(0, 4) != 0, $urandom_range(0, 4) != 0,
               $urandom_range(0, 2) == 0, $urandom_range(0, 1) == 1,
               $urandom_range(0, 3));
    end

    @(negedge clk);
    chk(ld_ready && pulses() == 3'b000, "R9", "idle at end",
        DW'({ld_ready, pulses()}), DW'({1'b1, 3'b000}));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule